// File: doc/BRIEF.md
# Adaptive-Slope Delta Modulation Encoder

This block turns a stream of signed PCM samples into a one-bit-per-clock delta-modulated stream. On each rising edge of the bit clock it compares the incoming sample with a local reconstruction held in an integrator. It sends out the sign of that difference, then moves the integrator one step toward the sample. The step size is not fixed. A short history of output bits is watched for a run of equal values, which is the sign of slope overload. Such a run charges a leaky syllabic filter, and the filter's value widens the step. When the history is mixed, the filter relaxes back toward the minimum step.

A decoder that runs the same step-adaptation rule on the received bits rebuilds the waveform, so no framing is needed. A force-idle input overrides the decision and makes the encoder emit an alternating silence pattern, which also serves to synchronize a link. The serial output bit changes on the falling edge of the bit clock, half a cycle after the decision is taken.

Top module: `cvsd_enc`

## Requirements
- R1: On each rising edge with idle low, the decision bit is 1 when the signed sample is strictly greater than the signed integrator value, else 0. A 1 raises the integrator by the current step and a 0 lowers it by the current step.
- R2: The history holds the last HIST decision bits, with HIST set to 3 or 4 (default 4), the newest included. Coincidence is true exactly when all HIST bits are equal.
- R3: The syllabic register updates every rising edge as syl - (syl >> DECAY) + (coincidence ? STEP_SPAN : 0), using the coincidence of the history that includes the new bit.
- R4: The step applied on an edge is STEP_MIN + (syl >> DECAY), taken from syl before that edge's update. It therefore spans STEP_MIN to STEP_MIN + STEP_SPAN (2 to 600 by default, 300:1).
- R5: A constant input, held until the syllabic register has decayed, gives a strictly alternating bit stream. A constant input at negative full scale (-2048) gives all zeros, because no integrator value lies below it.
- R6: While idle is high, the decision bit is the inverse of the previous decision bit whatever the sample, and the integrator and filter keep updating from that bit.
- R7: bit_out takes the decision made at a rising edge on the following falling edge and holds it until the next falling edge.
- R8: The integrator is 12-bit two's complement and saturates at 2047 and -2048 instead of wrapping.
- R9: Reset (rst_n low, asynchronous) sets the integrator to 0 and the syllabic register to 0, so the step is STEP_MIN. The history is set to alternating bits with the newest bit 0, and bit_out to 0. The first idle bit after reset is therefore 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; decisions on rising edge, output on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | W (12) | Signed two's complement input sample |
| idle_in | input | 1 | Force-idle: emit alternating pattern |
| bit_out | output | 1 | Serial delta-modulated output bit |

## Verification
On every cycle, the assertions check these invariants: each bit moves the integrator in its own direction, idle inverts the last bit, and a coincident history never lets the syllabic register fall while a mixed history never lets it rise. They also check that the register stays under its fixed-point ceiling. The exact step magnitudes, clamping at both rails, and the difference between a three-bit and a four-bit history only show up in the bench. There, a bit-exact arithmetic model runs alongside two instances through ramps, square waves, constant levels and idle periods. The half-cycle output timing, the steady-state alternation after decay, and the all-zero stream at negative full scale are likewise bench-only results.

// File: rtl/cvsd_enc.sv
module cvsd_enc #(
  parameter int W         = 12,
  parameter int HIST      = 4,
  parameter int STEP_MIN  = 2,
  parameter int STEP_SPAN = 598,
  parameter int DECAY     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] sample_in,
  input  logic                idle_in,
  output logic                bit_out
);
  localparam int SW = $clog2((STEP_SPAN + 1) << DECAY) + 1;
  localparam logic [HIST-1:0] ALT = HIST'(32'hAAAA_AAAA);
  localparam int IMAX = 2 ** (W - 1) - 1;
  localparam int IMIN = -(2 ** (W - 1));

  logic signed [W-1:0] integ;
  logic [SW-1:0]       syl;
  logic [HIST-1:0]     hist;

  logic                dec;
  logic [HIST-1:0]     hist_n;
  logic                coinc;
  logic [W-1:0]        step;
  logic signed [W+1:0] wide, sum;
  logic signed [W-1:0] integ_n;
  logic [SW-1:0]       syl_n;

  assign dec    = idle_in ? ~hist[0] : (sample_in > integ);
  assign hist_n = {hist[HIST-2:0], dec};
  assign coinc  = (&hist_n) | ~(|hist_n);
  assign step   = W'(STEP_MIN) + W'(syl >> DECAY);
  assign wide   = {{2{integ[W-1]}}, integ};
  assign sum    = dec ? wide + $signed({2'b00, step}) : wide - $signed({2'b00, step});

  always_comb begin
    if (sum > (W+2)'(IMAX))      integ_n = W'(IMAX);
    else if (sum < (W+2)'(IMIN)) integ_n = W'(IMIN);
    else                         integ_n = sum[W-1:0];
  end

  assign syl_n = syl - (syl >> DECAY) + (coinc ? SW'(STEP_SPAN) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ <= '0;
      syl   <= '0;
      hist  <= ALT;
    end else begin
      integ <= integ_n;
      syl   <= syl_n;
      hist  <= hist_n;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) bit_out <= ALT[0];
    else        bit_out <= hist[0];
  end
endmodule

// File: rtl/cvsd_enc_chk.sv
module cvsd_enc_chk #(
  parameter int W         = 12,
  parameter int HIST      = 4,
  parameter int STEP_SPAN = 598,
  parameter int DECAY     = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                idle_in,
  input logic signed [W-1:0] integ,
  input logic [$clog2((STEP_SPAN + 1) << DECAY):0] syl,
  input logic [HIST-1:0]     hist
);
  localparam int SW = $clog2((STEP_SPAN + 1) << DECAY) + 1;
  localparam logic [SW-1:0] CEIL = SW'(((STEP_SPAN + 1) << DECAY) - 1);

  a_r6_idle_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    idle_in |=> (hist[0] != $past(hist[0])));

  a_r1_direction: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hist[0] ? (integ >= $past(integ)) : (integ <= $past(integ))));

  a_r3_relax: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((&hist) || !(|hist) || (syl <= $past(syl))));

  a_r3_charge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!((&hist) || !(|hist)) || (syl >= $past(syl))));

  a_r4_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    syl <= CEIL);
endmodule

bind cvsd_enc cvsd_enc_chk #(.W(W), .HIST(HIST), .STEP_SPAN(STEP_SPAN), .DECAY(DECAY))
  u_chk (.clk(clk), .rst_n(rst_n), .idle_in(idle_in), .integ(integ), .syl(syl), .hist(hist));

// File: tb/cvsd_enc_tb.sv
module cvsd_enc_tb;
  localparam int SMIN = 2, SPAN = 598, D = 8;

  logic clk = 0, rst_n = 0, idle_in = 0;
  logic signed [11:0] sample_in = '0;
  logic bit_out, bit_out3;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_integ[2], m_syl[2], m_hist[2];
  int hl[2] = '{4, 3};
  bit e0, e1, prev0;
  int lastbits;

  always #5 clk = ~clk;

  cvsd_enc #(.HIST(4)) u_dut  (.clk(clk), .rst_n(rst_n), .sample_in(sample_in), .idle_in(idle_in), .bit_out(bit_out));
  cvsd_enc #(.HIST(3)) u_dut3 (.clk(clk), .rst_n(rst_n), .sample_in(sample_in), .idle_in(idle_in), .bit_out(bit_out3));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model(input int k, input int s, input bit idle, output bit d);
    int step, ni, mask;
    mask = (1 << hl[k]) - 1;
    d = idle ? ((m_hist[k] & 1) == 0) : (s > m_integ[k]);
    step = SMIN + (m_syl[k] >> D);
    ni = d ? m_integ[k] + step : m_integ[k] - step;
    if (ni > 2047) ni = 2047;
    if (ni < -2048) ni = -2048;
    m_integ[k] = ni;
    m_hist[k] = ((m_hist[k] << 1) | int'(d)) & mask;
    m_syl[k] = m_syl[k] - (m_syl[k] >> D) +
               ((m_hist[k] == mask || m_hist[k] == 0) ? SPAN : 0);
  endtask

  task automatic run(input int s, input bit idle, input string tag);
    sample_in = 12'(s);
    idle_in = idle;
    @(posedge clk);
    prev0 = e0;
    model(0, s, idle, e0);
    model(1, s, idle, e1);
    lastbits = (lastbits << 1) | int'(e0);
    #3;
    chk(bit_out == prev0, "R7 hold before falling edge", int'(bit_out), int'(prev0));
    #5;
    chk(bit_out == e0, tag, int'(bit_out), int'(e0));
    chk(bit_out3 == e1, tag, int'(bit_out3), int'(e1));
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lvl[4] = '{0, 1000, -700, 2047};
    int lcg = 12345;
    for (int k = 0; k < 2; k++) begin
      m_integ[k] = 0; m_syl[k] = 0; m_hist[k] = 'hAA & ((1 << hl[k]) - 1);
    end
    e0 = 0; lastbits = 0;
    repeat (3) @(posedge clk);
    #8;
    chk(bit_out == 0, "R9 reset bit_out", int'(bit_out), 0);
    chk(bit_out3 == 0, "R9 reset bit_out HIST3", int'(bit_out3), 0);
    rst_n = 1;

    // R9 then R6: first idle bit is 1, then toggling
    run(0, 1, "R6 idle after reset");
    chk(e0 == 1 && bit_out == 1, "R9 first idle bit", int'(bit_out), 1);
    for (int i = 0; i < 11; i++) begin
      run(((i * 977) % 4096) - 2048, 1, "R6 idle stream");
      chk(bit_out != prev0, "R6 toggle", int'(bit_out), int'(!prev0));
    end

    // R3 decay under constant levels, then R5 alternation
    for (int j = 0; j < 4; j++) begin
      for (int i = 0; i < 3000; i++) run(lvl[j], 0, "R3 constant level");
      for (int i = 0; i < 8; i++) begin
        run(lvl[j], 0, "R5 steady");
        chk(bit_out != prev0, "R5 alternation", int'(bit_out), int'(!prev0));
      end
    end

    // R5 / R8 negative full scale
    for (int i = 0; i < 200; i++) run(-2048, 0, "R8 negative rail");
    chk((lastbits & 'hFF) == 0, "R5 all zeros at -2048", lastbits & 'hFF, 0);

    // R1 full ramp up and down
    for (int v = -2048; v < 2048; v++) run(v, 0, "R1 ramp up");
    for (int v = 2047; v >= -2048; v--) run(v, 0, "R1 ramp down");

    // R2 R4 slope overload with square wave
    for (int i = 0; i < 1024; i++) run(((i / 64) % 2) ? 1800 : -1800, 0, "R2 R4 overload");

    // R8 full-scale square reaching both rails
    for (int i = 0; i < 2048; i++) run(((i / 256) % 2) ? -2048 : 2047, 0, "R8 saturation");

    // R6 idle mid-stream with pseudo-random input
    for (int i = 0; i < 40; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7FFF_FFFF;
      run((lcg % 4096) - 2048, 1, "R6 idle mid-stream");
      chk(bit_out != prev0, "R6 toggle ignores input", int'(bit_out), int'(!prev0));
    end
    for (int i = 0; i < 500; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7FFF_FFFF;
      run((lcg % 4096) - 2048, 0, "R2 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule